// File: doc/BRIEF.md
# Real-Time Clock Timebase and Rate Selector

This block is the timebase of a real-time clock. A 32.768 kHz tick enable, one system clock wide, advances a 15-stage binary divider. A 4-bit rate code selects one of 13 divider stages, or none. The selected stage feeds a square-wave output that an enable input can hold low. The same stage also produces a one-cycle periodic-event pulse on each of its rising edges. So the square wave and the periodic event always run at the same rate.

A 3-bit oscillator control code has three effects. It can let the divider count. It can keep the oscillator alive while holding the divider at zero. It can stop counting altogether. The block also derives the once-per-second update-transfer strobe from the top divider stage. It raises an update-pending status 8 ticks (about 244 µs) before each transfer. A freeze input drops that status and cancels the transfer, which lets software edit time registers safely.

Top module: `rtc_timebase`

## Requirements
- R1: With control code 3'b010 the divider advances by one on every cycle where tick_i is high. At rate code 3 and tick_i high every cycle, sqw_o has a period of 4 cycles.
- R2: With control bits [2:1] equal to 2'b11, the divider is held at zero. sqw_o stays low, periodic_o, update_o and uip_o stay low, and counting resumes from zero.
- R3: Every control code other than 3'b010 and 3'b11x freezes the divider count regardless of tick_i. sqw_o stays constant, and no periodic_o or update_o pulse occurs.
- R4: The first update_o pulse comes 16384 ticks after leaving hold with code 3'b010. Later pulses come every 32768 ticks.
- R5: Rate code 1 selects 256 Hz and code 2 selects 128 Hz. Codes 3 to 15 select 8192 Hz down to 2 Hz, halving with each code step. At one tick per cycle, code 1 gives a 128-cycle square-wave period.
- R6: Rate code 0 selects no stage: sqw_o stays low and periodic_o never pulses.
- R7: With sqw_en_i low, sqw_o is low while periodic_o keeps pulsing at the selected rate.
- R8: periodic_o is a one-cycle pulse, one per period of the selected stage, on its rising edge. At code 5 this is 16 pulses in any 256-tick window.
- R9: uip_o rises 8 ticks before an update_o pulse and falls in the same cycle that update_o rises.
- R10: While freeze_i is high, uip_o is cleared and update_o is suppressed. A transfer whose pending window was cut by freeze does not occur.
- R11: update_o is a single-cycle pulse, and all outputs are low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz count enable |
| osc_ctl_i | input | 3 | Oscillator and divider control code |
| rate_sel_i | input | 4 | Divider stage select, 0 = none |
| sqw_en_i | input | 1 | Square-wave output enable |
| freeze_i | input | 1 | Suspend update transfers |
| sqw_o | output | 1 | Square wave at selected rate |
| periodic_o | output | 1 | One-cycle pulse per period of selected stage |
| update_o | output | 1 | One-cycle once-per-second transfer strobe |
| uip_o | output | 1 | Update-pending status |

## Verification
The functions that can land in the same cycle are the freeze request and the update transfer it cancels. The bench raises freeze_i in exactly the cycle in which the third transfer would fire, while uip_o is high. It then requires that no update_o pulse appears, that uip_o is low one cycle later, and that no late transfer follows. A behavioural model, built on integer counts and tap periods, is compared against all four outputs on every clock. This covers rate changes, tick gaps and control-code changes.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;
  localparam int CTL_W  = 3;
  localparam int RATE_W = 4;

  typedef enum logic [1:0] {
    OSC_OFF  = 2'd0,
    OSC_HOLD = 2'd1,
    OSC_RUN  = 2'd2
  } osc_mode_e;

  // rate code -> divider bit; two low codes map to slow taps
  function automatic int tap_index(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction
endpackage

// File: rtl/rtc_osc_decode.sv
module rtc_osc_decode
  import rtc_timebase_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  output osc_mode_e        mode_o
);
  always_comb begin
    if (ctl_i == 3'b010)          mode_o = OSC_RUN;
    else if (ctl_i[2:1] == 2'b11) mode_o = OSC_HOLD;
    else                          mode_o = OSC_OFF;
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_timebase_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  osc_mode_e         mode_i,
  output logic [STAGES-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (mode_i == OSC_HOLD)         cnt_o <= '0;
    else if (mode_i == OSC_RUN && tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rtc_tap_mux.sv
module rtc_tap_mux
  import rtc_timebase_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int SEL_W  = RATE_W
) (
  input  logic [STAGES-1:0] cnt_i,
  input  logic [SEL_W-1:0]  rate_i,
  output logic              tap_o
);
  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] taps;

  assign taps[0] = 1'b0;

  for (genvar c = 1; c < NCODE; c++) begin : g_tap
    localparam int IDX = tap_index(c);
    if (IDX >= 0 && IDX < STAGES) begin : g_on
      assign taps[c] = cnt_i[IDX];
    end else begin : g_off
      assign taps[c] = 1'b0;
    end
  end

  assign tap_o = taps[rate_i];
endmodule

// File: rtl/rtc_update_timer.sv
module rtc_update_timer
  import rtc_timebase_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  osc_mode_e         mode_i,
  input  logic              freeze_i,
  input  logic [STAGES-1:0] cnt_i,
  output logic              update_o,
  output logic              uip_o
);
  localparam int XFER_N = (1 << (STAGES - 1)) - 1;
  localparam int UIP_N  = XFER_N - UIP_LEAD;

  logic advance, at_xfer, at_uip;

  assign advance = tick_i && (mode_i == OSC_RUN);
  assign at_xfer = advance && (cnt_i == STAGES'(XFER_N));
  assign at_uip  = advance && (cnt_i == STAGES'(UIP_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_o    <= 1'b0;
      update_o <= 1'b0;
    end else begin
      update_o <= at_xfer && uip_o && !freeze_i;
      if (freeze_i || mode_i == OSC_HOLD) uip_o <= 1'b0;
      else if (at_uip)                    uip_o <= 1'b1;
      else if (at_xfer)                   uip_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_timebase_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CTL_W-1:0]  osc_ctl_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              sqw_en_i,
  input  logic              freeze_i,
  output logic              sqw_o,
  output logic              periodic_o,
  output logic              update_o,
  output logic              uip_o
);
  osc_mode_e         mode;
  logic [STAGES-1:0] cnt;
  logic              tap, tap_q;

  rtc_osc_decode u_dec (
    .ctl_i  (osc_ctl_i),
    .mode_o (mode)
  );

  rtc_div_chain #(.STAGES(STAGES)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .mode_i (mode),
    .cnt_o  (cnt)
  );

  rtc_tap_mux #(.STAGES(STAGES), .SEL_W(RATE_W)) u_mux (
    .cnt_i  (cnt),
    .rate_i (rate_sel_i),
    .tap_o  (tap)
  );

  rtc_update_timer #(.STAGES(STAGES), .UIP_LEAD(UIP_LEAD)) u_upd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .mode_i   (mode),
    .freeze_i (freeze_i),
    .cnt_i    (cnt),
    .update_o (update_o),
    .uip_o    (uip_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q      <= 1'b0;
      periodic_o <= 1'b0;
    end else begin
      tap_q      <= tap;
      periodic_o <= tap && !tap_q;
    end
  end

  assign sqw_o = sqw_en_i && tap_q;
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] osc_ctl_i,
  input logic [3:0] rate_sel_i,
  input logic       freeze_i,
  input logic       sqw_o,
  input logic       periodic_o,
  input logic       update_o,
  input logic       uip_o
);
  logic hold, stop;
  assign hold = (osc_ctl_i[2:1] == 2'b11);
  assign stop = (osc_ctl_i != 3'b010) && !hold;

  p_hold_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold, 2) && $past(hold)) |-> (!periodic_o && !update_o && !uip_o && !sqw_o));

  p_stop_static_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop) && !$past(freeze_i)) |-> ($stable(uip_o) && !update_o));

  p_rate_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rate_sel_i) == 4'd0) |-> (!periodic_o && !sqw_o));

  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periodic_o |=> !periodic_o);

  p_uip_before_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($past(uip_o) && !uip_o));

  p_freeze_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> (!uip_o && !update_o));

  p_update_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);
endmodule

bind rtc_timebase rtc_timebase_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_ctl_i  (osc_ctl_i),
  .rate_sel_i (rate_sel_i),
  .freeze_i   (freeze_i),
  .sqw_o      (sqw_o),
  .periodic_o (periodic_o),
  .update_o   (update_o),
  .uip_o      (uip_o)
);

// File: tb/rtc_timebase_tb.sv
module rtc_timebase_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [2:0] osc_ctl_i = 3'b000;
  logic [3:0] rate_sel_i = 4'd0;
  logic       sqw_en_i = 1'b0;
  logic       freeze_i = 1'b0;
  logic       sqw_o, periodic_o, update_o, uip_o;

  always #4 clk = ~clk;

  rtc_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .osc_ctl_i(osc_ctl_i),
    .rate_sel_i(rate_sel_i), .sqw_en_i(sqw_en_i), .freeze_i(freeze_i),
    .sqw_o(sqw_o), .periodic_o(periodic_o), .update_o(update_o), .uip_o(uip_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int m_cnt = 0;
  bit m_tap = 0, m_per = 0, m_upd = 0, m_uip = 0;
  int per_n = 0, sqw_rises = 0, sqw_last = 0, sqw_period = 0;
  int upd_n = 0, upd_at[4] = '{0, 0, 0, 0}, uip_rise_at = 0;
  bit prev_sqw = 0, prev_uip = 0;
  bit done = 0;

  function automatic bit tap_model(int cnt, int rate);
    int f, half;
    if (rate == 0) return 0;
    f = (rate == 1) ? 256 : (rate == 2) ? 128 : (32768 >> (rate - 1));
    half = 32768 / (2 * f);
    return ((cnt / half) % 2) == 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model, event recorder and per-cycle comparison
  always @(posedge clk) begin
    bit run, hold, adv, tn, nu;
    cyc++;
    if (!rst_ni) begin
      m_cnt = 0; m_tap = 0; m_per = 0; m_upd = 0; m_uip = 0;
    end else begin
      run  = (osc_ctl_i == 3'b010);
      hold = (osc_ctl_i[2:1] == 2'b11);
      adv  = run && tick_i;
      tn   = tap_model(m_cnt, rate_sel_i);
      m_per = tn && !m_tap;
      m_tap = tn;
      nu = adv && m_cnt == 16383 && m_uip && !freeze_i;
      if (freeze_i || hold)          m_uip = 0;
      else if (adv && m_cnt == 16375) m_uip = 1;
      else if (adv && m_cnt == 16383) m_uip = 0;
      m_upd = nu;
      if (hold)     m_cnt = 0;
      else if (adv) m_cnt = (m_cnt + 1) % 32768;
    end
    #2;
    if (rst_ni && !done) begin
      chk(sqw_o == (sqw_en_i && m_tap), "R5 sqw model", sqw_o, sqw_en_i && m_tap);
      chk(periodic_o == m_per, "R8 periodic model", periodic_o, m_per);
      chk(update_o == m_upd, "R4 update model", update_o, m_upd);
      chk(uip_o == m_uip, "R9 uip model", uip_o, m_uip);
      if (periodic_o) per_n++;
      if (sqw_o && !prev_sqw) begin
        sqw_period = cyc - sqw_last; sqw_last = cyc; sqw_rises++;
      end
      if (uip_o && !prev_uip) uip_rise_at = cyc;
      if (update_o) begin
        if (upd_n < 4) upd_at[upd_n] = cyc;
        upd_n++;
      end
    end
    prev_sqw = sqw_o;
    prev_uip = uip_o;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R4 actual %0d expected below 150000", cyc);
      report();
    end
  end

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    int run0, s_per, s_rise, tgt;
    bit s_sqw;
    repeat (5) @(negedge clk);
    chk(!sqw_o && !periodic_o && !update_o && !uip_o, "R11 reset outputs", sqw_o + periodic_o + update_o + uip_o, 0);
    rst_ni = 1'b1;

    // R2: hold
    osc_ctl_i = 3'b110; rate_sel_i = 4'd3; sqw_en_i = 1'b1;
    repeat (3) @(negedge clk);
    s_rise = sqw_rises; s_per = per_n;
    repeat (20) @(negedge clk);
    chk(sqw_rises == s_rise && per_n == s_per && !sqw_o, "R2 hold quiet", sqw_rises - s_rise + per_n - s_per, 0);

    // R1: run at 8192 Hz
    osc_ctl_i = 3'b010; run0 = cyc;
    repeat (40) @(negedge clk);
    chk(sqw_period == 4, "R1 sqw period code 3", sqw_period, 4);

    // R5: code 1 -> 256 Hz
    rate_sel_i = 4'd1;
    repeat (400) @(negedge clk);
    chk(sqw_period == 128, "R5 sqw period code 1", sqw_period, 128);
    rate_sel_i = 4'd2;
    repeat (800) @(negedge clk);
    chk(sqw_period == 256, "R5 sqw period code 2", sqw_period, 256);

    // R8: 16 pulses in 256 ticks at code 5
    rate_sel_i = 4'd5;
    repeat (40) @(negedge clk);
    s_per = per_n;
    repeat (256) @(negedge clk);
    chk(per_n - s_per == 16, "R8 pulse count code 5", per_n - s_per, 16);

    // R6: no tap
    rate_sel_i = 4'd0;
    repeat (2) @(negedge clk);
    s_per = per_n; s_rise = sqw_rises;
    repeat (200) @(negedge clk);
    chk(per_n == s_per && sqw_rises == s_rise && !sqw_o, "R6 code 0 silent", per_n - s_per + sqw_rises - s_rise, 0);

    // R7: square wave gated, periodic continues
    rate_sel_i = 4'd3; sqw_en_i = 1'b0;
    repeat (2) @(negedge clk);
    s_per = per_n; s_rise = sqw_rises;
    repeat (100) @(negedge clk);
    chk(sqw_rises == s_rise && !sqw_o, "R7 sqw gated low", sqw_rises - s_rise, 0);
    chk(per_n - s_per == 25, "R7 periodic continues", per_n - s_per, 25);
    sqw_en_i = 1'b1;

    // R4/R9/R11: first and second transfers
    wait_cyc(run0 + 16384 + 2);
    chk(upd_n == 1 && upd_at[0] - run0 == 16384, "R4 first update delay", upd_at[0] - run0, 16384);
    chk(upd_at[0] - uip_rise_at == 8, "R9 uip lead", upd_at[0] - uip_rise_at, 8);
    chk(!update_o && !uip_o, "R11 update single cycle", update_o + uip_o, 0);
    wait_cyc(upd_at[0] + 32768 + 2);
    chk(upd_n == 2 && upd_at[1] - upd_at[0] == 32768, "R4 update interval", upd_at[1] - upd_at[0], 32768);

    // R10: freeze in the exact transfer cycle
    tgt = upd_at[1] + 32768;
    wait_cyc(tgt - 1);
    chk(uip_o == 1'b1, "R9 uip high before transfer", uip_o, 1);
    freeze_i = 1'b1;
    @(negedge clk);
    chk(!update_o && !uip_o, "R10 freeze collision", update_o + uip_o, 0);
    @(negedge clk);
    freeze_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(upd_n == 2 && !uip_o, "R10 transfer cancelled", upd_n, 2);

    // R3: stopped oscillator
    osc_ctl_i = 3'b001;
    repeat (2) @(negedge clk);
    s_sqw = sqw_o; s_per = per_n; s_rise = sqw_rises;
    repeat (100) @(negedge clk);
    chk(sqw_o == s_sqw && sqw_rises == s_rise && per_n == s_per, "R3 stopped static", per_n - s_per + sqw_rises - s_rise, 0);

    // gapped ticks, model comparison only
    osc_ctl_i = 3'b010; rate_sel_i = 4'd4;
    for (int k = 0; k < 600; k++) begin
      tick_i = (k % 3 == 0);
      @(negedge clk);
    end
    tick_i = 1'b1;

    // R2 again from running state
    osc_ctl_i = 3'b111;
    repeat (3) @(negedge clk);
    s_per = per_n;
    repeat (20) @(negedge clk);
    chk(per_n == s_per && !sqw_o && !uip_o, "R2 hold after run", per_n - s_per, 0);

    done = 1;
    report();
  end
endmodule